// File: doc/BRIEF.md
# Two-Channel Edge Interrupt Controller

This block collects interrupt events for two channels and hands them to a CPU one at a time. Each channel picks one of several active-low lines with a 3-bit select code: a counter carry pulse, a counter borrow pulse, an external pin, the combination of carry and borrow, or a latched quadrature pulse. Every raw line passes through a two-flop synchroniser. The selected line is then sampled once per sample period. A sampled high-to-low step raises a pending flag for that channel.

A small arbiter turns pending flags into grants. A grant is a one-cycle `irq_valid` pulse together with a vector number. A periodic tick request has the highest priority. It may be granted while an external service is still running, and it blocks new external grants until the CPU reports the end of the tick service. Only one external service may be open at a time, and the CPU closes it with the per-channel acknowledge. The block also shows the sampled level of a channel's external pin, and drives a wake output that tells an idle core an event is pending.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A channel's pending flag is set when two consecutive samples of its selected line read high then low. A line that stays low sets the flag only once.
- R2: Samples are taken once every SAMPLE_DIV clocks. A low lasting at least SAMPLE_DIV clocks at the input is always caught. The flag is set within SAMPLE_DIV+3 clocks of the input falling.
- R3: Select codes are: 0 = carry_n, 1 = borrow_n, 2 = pin_n, 3 = low when either carry_n or borrow_n is low, 4 = quad_n. Codes 5 to 7 hold the channel's line high, so the channel never becomes pending.
- R4: After a detection, the channel detects again only after its line has been sampled high.
- R5: When a channel's code is 2, line_status shows the last sampled pin level (1 = high). For any other code it reads 1.
- R6: A one-cycle int_ack clears the channel's pending flag. Further falling edges that arrive while the flag is set produce no extra grant.
- R7: If both channels are pending and no grant is blocked, channel 1 is granted before channel 0.
- R8: A grant is a one-cycle irq_valid pulse with irq_id 0 = channel 0, 1 = channel 1, 2 = tick. After an external grant, no further external grant is issued until int_ack arrives for the granted channel.
- R9: From a tick grant until tick_done, no external grant is issued. Pending external events are granted after tick_done.
- R10: A tick_req is granted even while an external service is open. The external service stays open until its int_ack.
- R11: wake is high exactly when at least one channel flag is pending.
- R12: After reset: irq_valid = 0, wake = 0, line_status = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel0 | input | 3 | Source select code, channel 0 |
| src_sel1 | input | 3 | Source select code, channel 1 |
| carry_n | input | 2 | Counter carry pulse per channel, active low |
| borrow_n | input | 2 | Counter borrow pulse per channel, active low |
| pin_n | input | 2 | External interrupt pin per channel, active low |
| quad_n | input | 2 | Latched quadrature pulse per channel, active low |
| int_ack | input | 2 | Per-channel acknowledge pulse from the CPU |
| tick_req | input | 1 | Periodic tick request pulse |
| tick_done | input | 1 | End of tick service pulse |
| irq_valid | output | 1 | One-cycle grant strobe |
| irq_id | output | 2 | Granted vector: 0 ch0, 1 ch1, 2 tick |
| line_status | output | 2 | Sampled pin level per channel |
| wake | output | 1 | Any channel pending |

## Verification
A flag stuck set shows within a few clocks. wake stays high after the acknowledge, and a repeated grant appears as soon as the arbiter is free. A lost sample register or a broken rearm rule shows as a missing grant or an extra grant within two sample periods of the line moving. A busy bit in the arbiter that is never cleared shows as a grant that never arrives after int_ack or tick_done. A busy bit that is cleared too early shows as an external grant overlapping a tick service, and the bound checker flags it on the next cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [2:0] {
    SRC_CARRY  = 3'd0,
    SRC_BORROW = 3'd1,
    SRC_PIN    = 3'd2,
    SRC_EITHER = 3'd3,
    SRC_QUAD   = 3'd4
  } src_sel_e;

  localparam int unsigned NUM_SRC = 4;
  localparam logic [1:0] VEC_CH0  = 2'd0;
  localparam logic [1:0] VEC_CH1  = 2'd1;
  localparam logic [1:0] VEC_TICK = 2'd2;
endpackage

// File: rtl/eirq_rst_sync.sv
module eirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_strobe.sv
module eirq_strobe #(
  parameter int unsigned SAMPLE_DIV = 45
) (
  input  logic clk,
  input  logic rst_n,
  output logic smp_en
);
  generate
    if (SAMPLE_DIV <= 1) begin : g_every
      assign smp_en = 1'b1;
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(SAMPLE_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_DIV - 1);
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             wrap;

      always_comb begin
        wrap  = (cnt_q == LAST);
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign smp_en = wrap;
    end
  endgenerate
endmodule

// File: rtl/eirq_channel.sv
module eirq_channel
  import eirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic [2:0] sel,
  input  logic       carry_n,
  input  logic       borrow_n,
  input  logic       pin_n,
  input  logic       quad_n,
  input  logic       ack,
  output logic       pend,
  output logic       status
);
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] stage_q [SYNC_STAGES];
  logic [NUM_SRC-1:0] safe;
  logic               line;
  logic               samp_q, samp_d;
  logic               pend_q, pend_d;
  logic               fall;

  assign raw = {quad_n, pin_n, borrow_n, carry_n};

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= raw;
        else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign safe = stage_q[SYNC_STAGES-1];

  always_comb begin
    case (sel)
      SRC_CARRY:  line = safe[0];
      SRC_BORROW: line = safe[1];
      SRC_PIN:    line = safe[2];
      SRC_EITHER: line = safe[0] & safe[1];
      SRC_QUAD:   line = safe[3];
      default:    line = 1'b1;
    endcase
  end

  always_comb begin
    fall   = smp_en & samp_q & ~line;
    samp_d = smp_en ? line : samp_q;
    pend_d = fall | (pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      pend_q <= pend_d;
    end
  end

  assign pend   = pend_q;
  assign status = (sel == SRC_PIN) ? samp_q : 1'b1;
endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter
  import eirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pend,
  input  logic [1:0] ack,
  input  logic       tick_req,
  input  logic       tick_done,
  output logic       valid,
  output logic [1:0] vec_id
);
  logic       tick_pend_q, tick_pend_d;
  logic       tick_busy_q, tick_busy_d;
  logic       ext_busy_q, ext_busy_d;
  logic       ext_ch_q, ext_ch_d;
  logic       valid_q, valid_d;
  logic [1:0] id_q, id_d;
  logic [1:0] live;
  logic       tick_want, give_tick, give_ext, pick;

  always_comb begin
    live      = pend & ~ack;
    tick_want = tick_pend_q | tick_req;
    give_tick = tick_want & ~tick_busy_q;
    give_ext  = ~give_tick & ~tick_busy_q & ~ext_busy_q & (|live);
    pick      = live[1];

    tick_pend_d = tick_want & ~give_tick;
    tick_busy_d = give_tick | (tick_busy_q & ~tick_done);

    ext_busy_d = ext_busy_q;
    ext_ch_d   = ext_ch_q;
    if (give_ext) begin
      ext_busy_d = 1'b1;
      ext_ch_d   = pick;
    end else if (ext_busy_q && ack[ext_ch_q]) begin
      ext_busy_d = 1'b0;
    end

    valid_d = give_tick | give_ext;
    if (give_tick)     id_d = VEC_TICK;
    else if (give_ext) id_d = pick ? VEC_CH1 : VEC_CH0;
    else               id_d = id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_pend_q <= 1'b0;
      tick_busy_q <= 1'b0;
      ext_busy_q  <= 1'b0;
      ext_ch_q    <= 1'b0;
      valid_q     <= 1'b0;
      id_q        <= VEC_CH0;
    end else begin
      tick_pend_q <= tick_pend_d;
      tick_busy_q <= tick_busy_d;
      ext_busy_q  <= ext_busy_d;
      ext_ch_q    <= ext_ch_d;
      valid_q     <= valid_d;
      id_q        <= id_d;
    end
  end

  assign valid  = valid_q;
  assign vec_id = id_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV  = 45,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src_sel0,
  input  logic [2:0] src_sel1,
  input  logic [1:0] carry_n,
  input  logic [1:0] borrow_n,
  input  logic [1:0] pin_n,
  input  logic [1:0] quad_n,
  input  logic [1:0] int_ack,
  input  logic       tick_req,
  input  logic       tick_done,
  output logic       irq_valid,
  output logic [1:0] irq_id,
  output logic [1:0] line_status,
  output logic       wake
);
  localparam int unsigned NCH = 2;

  logic             rst_sync_n;
  logic             smp_en;
  logic [2:0]       sel_w [NCH];
  logic [NCH-1:0]   pend_w;

  assign sel_w[0] = src_sel0;
  assign sel_w[1] = src_sel1;

  eirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  eirq_strobe #(.SAMPLE_DIV(SAMPLE_DIV)) u_strobe (
    .clk(clk), .rst_n(rst_sync_n), .smp_en(smp_en)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      eirq_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
        .clk(clk), .rst_n(rst_sync_n), .smp_en(smp_en), .sel(sel_w[c]),
        .carry_n(carry_n[c]), .borrow_n(borrow_n[c]), .pin_n(pin_n[c]),
        .quad_n(quad_n[c]), .ack(int_ack[c]), .pend(pend_w[c]),
        .status(line_status[c])
      );
    end
  endgenerate

  eirq_arbiter u_arb (
    .clk(clk), .rst_n(rst_sync_n), .pend(pend_w), .ack(int_ack),
    .tick_req(tick_req), .tick_done(tick_done),
    .valid(irq_valid), .vec_id(irq_id)
  );

  assign wake = |pend_w;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pend,
  input logic [1:0] int_ack,
  input logic       tick_done,
  input logic       irq_valid,
  input logic [1:0] irq_id,
  input logic       wake
);
  logic ext_act, ext_gid, tick_act;
  logic ext_grant, tick_grant;

  assign ext_grant  = irq_valid && (irq_id != 2'd2);
  assign tick_grant = irq_valid && (irq_id == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_act  <= 1'b0;
      ext_gid  <= 1'b0;
      tick_act <= 1'b0;
    end else begin
      if (ext_grant) begin
        ext_act <= !int_ack[irq_id[0]];
        ext_gid <= irq_id[0];
      end else if (ext_act && int_ack[ext_gid]) begin
        ext_act <= 1'b0;
      end
      if (tick_grant)     tick_act <= !tick_done;
      else if (tick_done) tick_act <= 1'b0;
    end
  end

  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_id != 2'd3)); // R8
  AST_ONE_EXT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ext_act |-> !ext_grant); // R8
  AST_TICK_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_act |-> !ext_grant); // R9
  AST_CH1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_id == 2'd0) |-> !$past(pend[1] & ~int_ack[1])); // R7
  AST_EXT_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_grant |-> $past(wake)); // R11
endmodule

bind edge_irq_ctrl eirq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pend(pend_w), .int_ack(int_ack),
  .tick_done(tick_done), .irq_valid(irq_valid), .irq_id(irq_id), .wake(wake)
);

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
  localparam int DIV = 45;
  localparam int NV  = 12;
  // fields: {select code[5:3], driven source[2:1] (0 carry,1 borrow,2 pin,3 quad), expect[0]}
  localparam logic [5:0] VEC [NV] = '{
    6'b000_00_1, 6'b000_01_0, 6'b001_01_1, 6'b001_10_0,
    6'b010_10_1, 6'b010_11_0, 6'b011_00_1, 6'b011_01_1,
    6'b100_11_1, 6'b100_00_0, 6'b101_10_0, 6'b111_00_0
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] src_sel0, src_sel1;
  logic [1:0] carry_n, borrow_n, pin_n, quad_n, int_ack;
  logic tick_req, tick_done;
  logic irq_valid, wake;
  logic [1:0] irq_id, line_status;

  int total = 0, bad = 0, gcnt = 0;
  logic [1:0] last_id = 2'd3;

  always #2 clk = ~clk;

  edge_irq_ctrl #(.SAMPLE_DIV(DIV), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .src_sel0(src_sel0), .src_sel1(src_sel1),
    .carry_n(carry_n), .borrow_n(borrow_n), .pin_n(pin_n), .quad_n(quad_n),
    .int_ack(int_ack), .tick_req(tick_req), .tick_done(tick_done),
    .irq_valid(irq_valid), .irq_id(irq_id), .line_status(line_status), .wake(wake)
  );

  always @(posedge clk) begin
    if (irq_valid) begin
      gcnt    <= gcnt + 1;
      last_id <= irq_id;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(input int ch, input int src, input logic v);
    case (src)
      0: carry_n[ch]  = v;
      1: borrow_n[ch] = v;
      2: pin_n[ch]    = v;
      default: quad_n[ch] = v;
    endcase
  endtask

  task automatic pulse_ack(input int ch);
    int_ack[ch] = 1'b1; cyc(1); int_ack[ch] = 1'b0;
  endtask

  task automatic expect_grant(input int prev, input int exp_id, input string tag);
    for (int k = 0; k < 2*DIV + 8 && gcnt == prev; k++) cyc(1);
    chk(gcnt == prev + 1, tag, gcnt - prev, 1);
    chk(last_id == exp_id[1:0], tag, last_id, exp_id);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int prev;
    rst_n = 1'b0; src_sel0 = 3'd7; src_sel1 = 3'd7;
    carry_n = '1; borrow_n = '1; pin_n = '1; quad_n = '1; int_ack = '0;
    tick_req = 1'b0; tick_done = 1'b0;
    cyc(5);
    chk(irq_valid == 1'b0, "R12 valid", irq_valid, 0);
    chk(wake == 1'b0, "R12 wake", wake, 0);
    chk(line_status == 2'b11, "R12 status", line_status, 3);
    rst_n = 1'b1;
    cyc(4);

    // R3 / R1: walk the select table on channel 0
    for (int i = 0; i < NV; i++) begin
      logic [5:0] v;
      v = VEC[i];
      src_sel0 = v[5:3];
      cyc(2);
      prev = gcnt;
      set_src(0, int'(v[2:1]), 1'b0);
      cyc(2*DIV);
      chk(wake == v[0], "R3 wake", wake, v[0]);
      chk(gcnt - prev == int'(v[0]), "R3 grants", gcnt - prev, v[0]);
      if (v[0]) begin
        chk(last_id == 2'd0, "R1 id", last_id, 0);
        pulse_ack(0);
        cyc(2);
        chk(wake == 1'b0, "R6 cleared", wake, 0);
      end
      set_src(0, int'(v[2:1]), 1'b1);
      cyc(2*DIV);
    end

    // R5: pin status
    src_sel0 = 3'd2;
    chk(line_status[0] == 1'b1, "R5 idle", line_status[0], 1);
    pin_n[0] = 1'b0; prev = gcnt;
    cyc(DIV + 4);
    chk(line_status[0] == 1'b0, "R5 low", line_status[0], 0);
    src_sel0 = 3'd0; cyc(1);
    chk(line_status[0] == 1'b1, "R5 other code", line_status[0], 1);
    src_sel0 = 3'd2; cyc(1);
    expect_grant(prev, 0, "R1 pin");
    pulse_ack(0);
    // R4: stays low, no redetect
    prev = gcnt;
    cyc(3*DIV);
    chk(gcnt == prev, "R4 held low", gcnt - prev, 0);
    chk(wake == 1'b0, "R4 wake", wake, 0);
    pin_n[0] = 1'b1; cyc(2*DIV);
    pin_n[0] = 1'b0;
    expect_grant(prev, 0, "R4 rearm");
    pulse_ack(0);
    pin_n[0] = 1'b1; cyc(2*DIV);

    // R6: second edge while pending, no ack in between
    prev = gcnt;
    pin_n[0] = 1'b0; cyc(2*DIV);
    pin_n[0] = 1'b1; cyc(2*DIV);
    pin_n[0] = 1'b0; cyc(2*DIV);
    chk(gcnt - prev == 1, "R6 one grant", gcnt - prev, 1);
    pulse_ack(0);
    cyc(2*DIV);
    chk(wake == 1'b0, "R6 wake", wake, 0);
    chk(gcnt - prev == 1, "R6 no extra", gcnt - prev, 1);
    pin_n[0] = 1'b1; cyc(2*DIV);

    // R2: low for exactly one sample period
    prev = gcnt;
    pin_n[0] = 1'b0; cyc(DIV); pin_n[0] = 1'b1;
    cyc(2*DIV);
    chk(gcnt - prev == 1, "R2 short low", gcnt - prev, 1);
    chk(wake == 1'b1, "R11 wake set", wake, 1);
    pulse_ack(0);
    cyc(2);
    chk(wake == 1'b0, "R11 wake clear", wake, 0);

    // R7: both channels together
    src_sel1 = 3'd2;
    cyc(2);
    prev = gcnt;
    pin_n = 2'b00;
    expect_grant(prev, 1, "R7 ch1 first");
    cyc(4);
    chk(gcnt - prev == 1, "R8 single ext", gcnt - prev, 1);
    pulse_ack(1);
    expect_grant(prev + 1, 0, "R7 ch0 next");
    pulse_ack(0);
    pin_n = 2'b11; cyc(2*DIV);

    // R9: tick defers external grant
    prev = gcnt;
    tick_req = 1'b1; cyc(1); tick_req = 1'b0;
    expect_grant(prev, 2, "R9 tick");
    pin_n[0] = 1'b0; cyc(2*DIV);
    chk(gcnt - prev == 1, "R9 held", gcnt - prev, 1);
    chk(wake == 1'b1, "R11 pending", wake, 1);
    tick_done = 1'b1; cyc(1); tick_done = 1'b0;
    expect_grant(prev + 1, 0, "R9 after done");
    pulse_ack(0);
    pin_n[0] = 1'b1; cyc(2*DIV);

    // R10: tick nests into an open external service
    prev = gcnt;
    pin_n[1] = 1'b0;
    expect_grant(prev, 1, "R10 ext");
    tick_req = 1'b1; cyc(1); tick_req = 1'b0;
    expect_grant(prev + 1, 2, "R10 tick");
    tick_done = 1'b1; cyc(1); tick_done = 1'b0;
    cyc(6);
    chk(gcnt - prev == 2, "R10 no regrant", gcnt - prev, 2);
    chk(wake == 1'b1, "R10 ext open", wake, 1);
    pulse_ack(1);
    cyc(4);
    chk(wake == 1'b0, "R10 closed", wake, 0);
    pin_n[1] = 1'b1; cyc(2*DIV);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule